// File: doc/BRIEF.md
# Delayed Register Update Queue

This block holds register writes that must not land until a number of timing ticks have passed. A producer posts a write into a small ring of slots, giving the target register, the kind of write, the operand width, a bit position, a value and a tick count. Every tick pulse counts down all pending slots together. A slot whose count runs out applies its write to a local register array. The write either replaces a whole register (all 64 bits, or only the low 32 bits) or sets or clears a single bit of it.

Slots commit in any order, as their counts run out, but space in the ring is freed strictly in posting order. A younger slot that commits early keeps its place until every older slot ahead of it has gone. Writes that land on the same tick are applied from the oldest to the youngest, so the youngest wins any overlap. A read port shows the contents of the register array, and the pending count shows how full the ring is.

Top module: `dq_delayed_update`

## Requirements
- R1: After reset, pend_count is 0, enq_ready is 1 and every register in the array reads 0.
- R2: A post (enq_valid high with enq_ready high) is accepted while fewer than SLOTS writes are pending. With SLOTS pending, enq_ready is 0, a post is ignored and pend_count is unchanged.
- R3: A write posted with tick count d (d >= 1) changes the array on the clock edge of the d-th tick pulse after the post. Cycles with tick low change no register.
- R4: A word write (enq_op = 0) with enq_wide = 1 replaces all 64 bits of the target. With enq_wide = 0 it replaces bits 31:0 and leaves bits 63:32 unchanged.
- R5: A bit write (enq_op = 1) sets the addressed bit when enq_value bit 0 is 1 and clears it when that bit is 0, and leaves every other bit of the target unchanged. The position is enq_bitpos[5:0] when enq_wide = 1 and enq_bitpos[4:0] when enq_wide = 0.
- R6: A tick count of 0 behaves like a tick count of 1.
- R7: Only the oldest pending write frees its slot. pend_count falls by at most one per tick pulse, and only once the oldest write has committed. A younger write that has already committed stays counted until it is the oldest.
- R8: Writes that commit on the same tick are applied in posting order, so the youngest wins on a shared target. Bit writes to different bits of one register all take effect.
- R9: A write posted in the same cycle as a tick pulse is not counted down by that tick.
- R10: Each write commits exactly once. When a write that committed early later frees its slot, the target keeps whatever was written to it after that commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Post a write this cycle |
| enq_ready | output | 1 | Ring has a free slot |
| enq_dest | input | 3 | Target register index |
| enq_op | input | 1 | 0 = word write, 1 = bit write |
| enq_wide | input | 1 | 1 = 64-bit operand, 0 = 32-bit operand |
| enq_bitpos | input | 6 | Bit position for bit writes |
| enq_value | input | 64 | Word data, or bit 0 = set/clear for bit writes |
| enq_delay | input | 4 | Tick count before commit |
| tick | input | 1 | Countdown pulse |
| rd_idx | input | 3 | Register array read index |
| rd_data | output | 64 | Register array read data (combinational) |
| pend_count | output | 4 | Number of occupied slots |

## Verification
The bench targets out-of-order commits. A design that frees a slot as soon as any write commits would show pend_count dropping too early. A design that lets an early slot commit a second time when it reaches the head would overwrite a newer value. Same-tick collisions are checked against the youngest-wins rule, which a reversed apply order breaks. Narrow bit writes use positions above 31, so a design that fails to fold the position into the low word changes the upper half instead. Further cases cover a post in a tick cycle (which an eager countdown commits one tick early), a zero tick count, a narrow word write against a register of all ones, and a post to a full ring, which must leave both the count and the register it names untouched.

// File: rtl/dq_pkg.sv
package dq_pkg;
   typedef enum logic {
      OP_WORD = 1'b0,
      OP_BIT  = 1'b1
   } dq_op_e;
endpackage

// File: rtl/dq_ring.sv
// Slot storage, per-slot countdown and in-order retirement.
module dq_ring #(
   parameter int SLOTS  = 8,
   parameter int IDX_W  = 3,
   parameter int POS_W  = 6,
   parameter int DATA_W = 64,
   parameter int DLY_W  = 4,
   parameter int PTR_W  = 3,
   parameter int CNT_W  = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              enq_valid,
   input  logic [IDX_W-1:0]                  enq_dest,
   input  logic                              enq_op,
   input  logic                              enq_wide,
   input  logic [POS_W-1:0]                  enq_pos,
   input  logic [DATA_W-1:0]                 enq_value,
   input  logic [DLY_W-1:0]                  enq_delay,
   input  logic                              tick,
   output logic                              enq_ready,
   output logic [CNT_W-1:0]                  count_o,
   output logic [PTR_W-1:0]                  in_ptr_o,
   output logic [PTR_W-1:0]                  out_ptr_o,
   output logic [SLOTS-1:0]                  fire_o,
   output logic [SLOTS-1:0][IDX_W-1:0]       s_dest,
   output logic [SLOTS-1:0]                  s_op,
   output logic [SLOTS-1:0]                  s_wide,
   output logic [SLOTS-1:0][POS_W-1:0]       s_pos,
   output logic [SLOTS-1:0][DATA_W-1:0]      s_val
);
   logic [PTR_W-1:0] in_q, out_q;
   logic [CNT_W-1:0] cnt_q;
   logic [SLOTS-1:0] occ;
   logic [SLOTS-1:0] done_q;
   logic             accept, head_go;

   assign enq_ready = (cnt_q != CNT_W'(SLOTS));
   assign accept    = enq_valid && enq_ready;
   assign head_go   = tick && (cnt_q != '0) && (done_q[out_q] || fire_o[out_q]);

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      logic [IDX_W-1:0]  dest_q;
      logic              op_q, wide_q;
      logic [POS_W-1:0]  pos_q;
      logic [DATA_W-1:0] val_q;
      logic [DLY_W-1:0]  dly_q;
      logic              dn_q;
      logic [PTR_W-1:0]  rel;

      assign rel       = PTR_W'(i) - out_q;
      assign occ[i]    = CNT_W'(rel) < cnt_q;
      assign fire_o[i] = tick && occ[i] && !dn_q && (dly_q <= DLY_W'(1));
      assign done_q[i] = dn_q;
      assign s_dest[i] = dest_q;
      assign s_op[i]   = op_q;
      assign s_wide[i] = wide_q;
      assign s_pos[i]  = pos_q;
      assign s_val[i]  = val_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            dest_q <= '0;
            op_q   <= 1'b0;
            wide_q <= 1'b0;
            pos_q  <= '0;
            val_q  <= '0;
            dly_q  <= '0;
            dn_q   <= 1'b0;
         end else if (accept && (in_q == PTR_W'(i))) begin
            dest_q <= enq_dest;
            op_q   <= enq_op;
            wide_q <= enq_wide;
            pos_q  <= enq_pos;
            val_q  <= enq_value;
            dly_q  <= enq_delay;
            dn_q   <= 1'b0;
         end else if (tick && occ[i] && !dn_q) begin
            if (fire_o[i]) dn_q <= 1'b1;
            if (dly_q != '0) dly_q <= dly_q - DLY_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_q  <= '0;
         out_q <= '0;
         cnt_q <= '0;
      end else begin
         in_q  <= in_q + PTR_W'(accept);
         out_q <= out_q + PTR_W'(head_go);
         cnt_q <= cnt_q + CNT_W'(accept) - CNT_W'(head_go);
      end
   end

   assign count_o   = cnt_q;
   assign in_ptr_o  = in_q;
   assign out_ptr_o = out_q;
endmodule

// File: rtl/dq_apply.sv
// Folds all commits of one tick into the next register array image, oldest first.
module dq_apply #(
   parameter int SLOTS    = 8,
   parameter int NREG     = 8,
   parameter int IDX_W    = 3,
   parameter int POS_W    = 6,
   parameter int NPOS_W   = 5,
   parameter int DATA_W   = 64,
   parameter int NARROW_W = 32,
   parameter int PTR_W    = 3
) (
   input  logic [PTR_W-1:0]                 out_ptr,
   input  logic [SLOTS-1:0]                 fire,
   input  logic [SLOTS-1:0][IDX_W-1:0]      s_dest,
   input  logic [SLOTS-1:0]                 s_op,
   input  logic [SLOTS-1:0]                 s_wide,
   input  logic [SLOTS-1:0][POS_W-1:0]      s_pos,
   input  logic [SLOTS-1:0][DATA_W-1:0]     s_val,
   input  logic [NREG-1:0][DATA_W-1:0]      rf_cur,
   output logic [NREG-1:0][DATA_W-1:0]      rf_nxt,
   output logic                             wr_en
);
   import dq_pkg::*;

   logic [POS_W-1:0] narrow_mask;

   if (NARROW_W == DATA_W) begin : g_same_width
      assign narrow_mask = '1;
   end else begin : g_split_width
      assign narrow_mask = POS_W'((1 << NPOS_W) - 1);
   end

   logic [PTR_W-1:0] sl;
   logic [IDX_W-1:0] dst;
   logic [POS_W-1:0] bp;

   always_comb begin
      rf_nxt = rf_cur;
      wr_en  = 1'b0;
      sl     = '0;
      dst    = '0;
      bp     = '0;
      for (int k = 0; k < SLOTS; k++) begin
         sl = out_ptr + PTR_W'(k);
         if (fire[sl]) begin
            wr_en = 1'b1;
            dst   = s_dest[sl];
            bp    = s_wide[sl] ? s_pos[sl] : (s_pos[sl] & narrow_mask);
            if (s_op[sl] == OP_BIT) begin
               rf_nxt[dst][bp] = s_val[sl][0];
            end else if (s_wide[sl]) begin
               rf_nxt[dst] = s_val[sl];
            end else begin
               rf_nxt[dst][NARROW_W-1:0] = s_val[sl][NARROW_W-1:0];
            end
         end
      end
   end
endmodule

// File: rtl/dq_regfile.sv
module dq_regfile #(
   parameter int NREG   = 8,
   parameter int DATA_W = 64,
   parameter int IDX_W  = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [NREG-1:0][DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]            rd_idx,
   output logic [DATA_W-1:0]           rd_data,
   output logic [NREG-1:0][DATA_W-1:0] cur
);
   logic [NREG-1:0][DATA_W-1:0] rf_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     rf_q <= '0;
      else if (wr_en) rf_q <= wr_data;
   end

   assign rd_data = rf_q[rd_idx];
   assign cur     = rf_q;
endmodule

// File: rtl/dq_delayed_update.sv
module dq_delayed_update #(
   parameter int SLOTS    = 8,
   parameter int NREG     = 8,
   parameter int DATA_W   = 64,
   parameter int NARROW_W = 32,
   parameter int DLY_W    = 4,
   localparam int IDX_W   = $clog2(NREG),
   localparam int POS_W   = $clog2(DATA_W),
   localparam int NPOS_W  = $clog2(NARROW_W),
   localparam int PTR_W   = $clog2(SLOTS),
   localparam int CNT_W   = PTR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enq_valid,
   output logic              enq_ready,
   input  logic [IDX_W-1:0]  enq_dest,
   input  logic              enq_op,
   input  logic              enq_wide,
   input  logic [POS_W-1:0]  enq_bitpos,
   input  logic [DATA_W-1:0] enq_value,
   input  logic [DLY_W-1:0]  enq_delay,
   input  logic              tick,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  pend_count
);
   if (SLOTS < 2 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
      $error("SLOTS must be a power of two of at least 2");
   end
   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("NREG must be a power of two of at least 2");
   end
   if (NARROW_W < 2 || NARROW_W > DATA_W || (NARROW_W & (NARROW_W - 1)) != 0
       || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("DATA_W and NARROW_W must be powers of two with NARROW_W <= DATA_W");
   end
   if (DLY_W < 1) begin : g_bad_dly
      $error("DLY_W must be at least 1");
   end

   logic [PTR_W-1:0]              ptr_in, ptr_out;
   logic [SLOTS-1:0]              fire;
   logic [SLOTS-1:0][IDX_W-1:0]   s_dest;
   logic [SLOTS-1:0]              s_op, s_wide;
   logic [SLOTS-1:0][POS_W-1:0]   s_pos;
   logic [SLOTS-1:0][DATA_W-1:0]  s_val;
   logic [NREG-1:0][DATA_W-1:0]   rf_cur, rf_nxt;
   logic                          rf_we;

   dq_ring #(
      .SLOTS(SLOTS), .IDX_W(IDX_W), .POS_W(POS_W), .DATA_W(DATA_W),
      .DLY_W(DLY_W), .PTR_W(PTR_W), .CNT_W(CNT_W)
   ) u_ring (
      .clk(clk), .rst_n(rst_n),
      .enq_valid(enq_valid), .enq_dest(enq_dest), .enq_op(enq_op),
      .enq_wide(enq_wide), .enq_pos(enq_bitpos), .enq_value(enq_value),
      .enq_delay(enq_delay), .tick(tick),
      .enq_ready(enq_ready), .count_o(pend_count),
      .in_ptr_o(ptr_in), .out_ptr_o(ptr_out), .fire_o(fire),
      .s_dest(s_dest), .s_op(s_op), .s_wide(s_wide), .s_pos(s_pos), .s_val(s_val)
   );

   dq_apply #(
      .SLOTS(SLOTS), .NREG(NREG), .IDX_W(IDX_W), .POS_W(POS_W), .NPOS_W(NPOS_W),
      .DATA_W(DATA_W), .NARROW_W(NARROW_W), .PTR_W(PTR_W)
   ) u_apply (
      .out_ptr(ptr_out), .fire(fire), .s_dest(s_dest), .s_op(s_op),
      .s_wide(s_wide), .s_pos(s_pos), .s_val(s_val),
      .rf_cur(rf_cur), .rf_nxt(rf_nxt), .wr_en(rf_we)
   );

   dq_regfile #(
      .NREG(NREG), .DATA_W(DATA_W), .IDX_W(IDX_W)
   ) u_rf (
      .clk(clk), .rst_n(rst_n), .wr_en(rf_we), .wr_data(rf_nxt),
      .rd_idx(rd_idx), .rd_data(rd_data), .cur(rf_cur)
   );
endmodule

// File: rtl/dq_delayed_update_chk.sv
module dq_delayed_update_chk #(
   parameter int SLOTS  = 8,
   parameter int IDX_W  = 3,
   parameter int DATA_W = 64,
   parameter int PTR_W  = 3,
   parameter int CNT_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enq_valid,
   input logic              enq_ready,
   input logic              tick,
   input logic [IDX_W-1:0]  rd_idx,
   input logic [DATA_W-1:0] rd_data,
   input logic [CNT_W-1:0]  pend_count,
   input logic [PTR_W-1:0]  ptr_in,
   input logic [PTR_W-1:0]  ptr_out
);
   // R2: never more than SLOTS pending
   p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pend_count <= CNT_W'(SLOTS));

   // R2: a post to a full ring without a tick leaves it full
   p_full_refuse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (enq_valid && (pend_count == CNT_W'(SLOTS)) && !tick) |=> (pend_count == CNT_W'(SLOTS)));

   // R2: an accepted post without a tick grows the count by one
   p_accept_grow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (enq_valid && enq_ready && !tick) |=> (pend_count == $past(pend_count) + CNT_W'(1)));

   // R7: pointers that differ imply a non-empty ring
   p_ptr_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_in != ptr_out) |-> (pend_count != '0));

   // R7: without a tick nothing retires
   p_no_retire_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> (pend_count >= $past(pend_count)));

   // R7: the count moves by at most one per cycle
   p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_count <= $past(pend_count) + CNT_W'(1)) &&
                ($past(pend_count) <= pend_count + CNT_W'(1))));

   // R3: cycles with tick low leave the array unchanged
   p_no_tick_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(rd_data) || !$stable(rd_idx)));
endmodule

bind dq_delayed_update dq_delayed_update_chk #(
   .SLOTS(SLOTS), .IDX_W(IDX_W), .DATA_W(DATA_W), .PTR_W(PTR_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
   .tick(tick), .rd_idx(rd_idx), .rd_data(rd_data), .pend_count(pend_count),
   .ptr_in(ptr_in), .ptr_out(ptr_out)
);

// File: tb/tb_dq_delayed_update.sv
module tb_dq_delayed_update;
   localparam int CLK_PERIOD = 10;
   localparam int SLOTS = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enq_valid = 1'b0;
   logic        enq_ready;
   logic [2:0]  enq_dest = '0;
   logic        enq_op = 1'b0;
   logic        enq_wide = 1'b0;
   logic [5:0]  enq_bitpos = '0;
   logic [63:0] enq_value = '0;
   logic [3:0]  enq_delay = '0;
   logic        tick = 1'b0;
   logic [2:0]  rd_idx = '0;
   logic [63:0] rd_data;
   logic [3:0]  pend_count;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   typedef struct {
      logic [2:0]  idx;
      logic [63:0] val;
      string       tag;
   } exp_t;
   exp_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   dq_delayed_update dut (
      .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
      .enq_dest(enq_dest), .enq_op(enq_op), .enq_wide(enq_wide),
      .enq_bitpos(enq_bitpos), .enq_value(enq_value), .enq_delay(enq_delay),
      .tick(tick), .rd_idx(rd_idx), .rd_data(rd_data), .pend_count(pend_count)
   );

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // driver side: record an expected register value
   task automatic expect_reg(logic [2:0] idx, logic [63:0] val, string tag);
      exp_t e;
      e.idx = idx; e.val = val; e.tag = tag;
      exp_q.push_back(e);
   endtask

   // monitor side: compare every queued expectation with the array
   task automatic score();
      while (exp_q.size() != 0) begin
         exp_t e;
         e = exp_q.pop_front();
         rd_idx = e.idx;
         #1;
         check(e.tag, rd_data, e.val);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
      enq_valid = 1'b0;
      tick = 1'b0;
   endtask

   task automatic post(logic [2:0] d, logic op, logic wide, logic [5:0] pos,
                       logic [63:0] v, logic [3:0] dly, logic tk);
      enq_valid = 1'b1; enq_dest = d; enq_op = op; enq_wide = wide;
      enq_bitpos = pos; enq_value = v; enq_delay = dly; tick = tk;
      cyc();
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1;
         cyc();
      end
   endtask

   task automatic drain();
      for (int i = 0; i < 40; i++) begin
         if (pend_count == 0) break;
         ticks(1);
      end
      check("R7 drained", 64'(pend_count), 64'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 count", 64'(pend_count), 64'd0);
      check("R1 ready", 64'(enq_ready), 64'd1);
      for (int r = 0; r < 8; r++) expect_reg(3'(r), 64'd0, "R1 reg zero");
      score();

      // R3/R4: wide word write after three ticks
      post(3'd1, 1'b0, 1'b1, 6'd0, 64'h0123_4567_89AB_CDEF, 4'd3, 1'b0);
      ticks(2);
      expect_reg(3'd1, 64'd0, "R3 not before third tick");
      score();
      ticks(1);
      expect_reg(3'd1, 64'h0123_4567_89AB_CDEF, "R4 wide word on third tick");
      score();
      check("R7 count after lone commit", 64'(pend_count), 64'd0);
      repeat (5) cyc();
      expect_reg(3'd1, 64'h0123_4567_89AB_CDEF, "R3 idle cycles");
      score();

      // R4 narrow word keeps upper half
      post(3'd2, 1'b0, 1'b1, 6'd0, 64'hFFFF_FFFF_FFFF_FFFF, 4'd1, 1'b0);
      ticks(1);
      post(3'd2, 1'b0, 1'b0, 6'd0, 64'hAAAA_AAAA_1234_5678, 4'd1, 1'b0);
      ticks(1);
      expect_reg(3'd2, 64'hFFFF_FFFF_1234_5678, "R4 narrow word");
      score();

      // R5 bit writes
      post(3'd3, 1'b0, 1'b1, 6'd0, 64'hF0F0_F0F0_F0F0_F0F0, 4'd1, 1'b0);
      ticks(1);
      post(3'd3, 1'b1, 1'b1, 6'd4, 64'd0, 4'd1, 1'b0);
      ticks(1);
      expect_reg(3'd3, 64'hF0F0_F0F0_F0F0_F0E0, "R5 clear bit 4");
      score();
      post(3'd3, 1'b1, 1'b1, 6'd63, 64'd0, 4'd1, 1'b0);
      ticks(1);
      post(3'd3, 1'b1, 1'b1, 6'd0, 64'd1, 4'd1, 1'b0);
      ticks(1);
      expect_reg(3'd3, 64'h70F0_F0F0_F0F0_F0E1, "R5 clear 63 set 0");
      score();
      post(3'd3, 1'b1, 1'b0, 6'd39, 64'd0, 4'd1, 1'b0);
      ticks(1);
      expect_reg(3'd3, 64'h70F0_F0F0_F0F0_F061, "R5 narrow position folds to 7");
      score();

      // R6 zero delay
      post(3'd4, 1'b0, 1'b1, 6'd0, 64'd5, 4'd0, 1'b0);
      ticks(1);
      expect_reg(3'd4, 64'd5, "R6 zero delay on first tick");
      score();

      // R7/R10: out-of-order commits, in-order retirement
      post(3'd5, 1'b0, 1'b1, 6'd0, 64'h11, 4'd4, 1'b0);
      post(3'd6, 1'b0, 1'b1, 6'd0, 64'h22, 4'd1, 1'b0);
      ticks(1);
      expect_reg(3'd6, 64'h22, "R7 younger commits early");
      expect_reg(3'd5, 64'h0, "R7 older still pending");
      score();
      check("R7 count held by head", 64'(pend_count), 64'd2);
      post(3'd6, 1'b0, 1'b1, 6'd0, 64'h33, 4'd1, 1'b0);
      ticks(1);
      expect_reg(3'd6, 64'h33, "R10 newer write lands");
      score();
      check("R7 count three", 64'(pend_count), 64'd3);
      ticks(1);
      check("R7 count still three", 64'(pend_count), 64'd3);
      ticks(1);
      expect_reg(3'd5, 64'h11, "R3 head on fourth tick");
      score();
      check("R7 head retired", 64'(pend_count), 64'd2);
      ticks(1);
      check("R7 one retire per tick", 64'(pend_count), 64'd1);
      expect_reg(3'd6, 64'h33, "R10 no second commit");
      score();
      ticks(1);
      check("R7 empty", 64'(pend_count), 64'd0);

      // R8 same-tick collisions
      post(3'd7, 1'b0, 1'b1, 6'd0, 64'hAAAA, 4'd1, 1'b0);
      post(3'd7, 1'b0, 1'b1, 6'd0, 64'hBBBB, 4'd1, 1'b0);
      post(3'd0, 1'b1, 1'b1, 6'd1, 64'd1, 4'd1, 1'b0);
      post(3'd0, 1'b1, 1'b1, 6'd2, 64'd1, 4'd1, 1'b0);
      ticks(1);
      expect_reg(3'd7, 64'hBBBB, "R8 youngest wins");
      expect_reg(3'd0, 64'h6, "R8 bit writes accumulate");
      score();
      drain();

      // R9 post during a tick is not counted down
      post(3'd1, 1'b0, 1'b1, 6'd0, 64'h99, 4'd1, 1'b1);
      expect_reg(3'd1, 64'h0123_4567_89AB_CDEF, "R9 not counted on post tick");
      score();
      ticks(1);
      expect_reg(3'd1, 64'h99, "R9 commits on next tick");
      score();
      drain();

      // R2 full ring refuses
      for (int i = 0; i < SLOTS; i++)
         post(3'd2, 1'b0, 1'b1, 6'd0, 64'h100 + 64'(i), 4'd2, 1'b0);
      check("R2 count full", 64'(pend_count), 64'(SLOTS));
      check("R2 ready low", 64'(enq_ready), 64'd0);
      post(3'd3, 1'b0, 1'b1, 6'd0, 64'hDEAD, 4'd1, 1'b0);
      check("R2 refused post", 64'(pend_count), 64'(SLOTS));
      ticks(2);
      expect_reg(3'd2, 64'h107, "R8 eight commits, last wins");
      score();
      check("R7 one retire of eight", 64'(pend_count), 64'(SLOTS - 1));
      drain();
      expect_reg(3'd3, 64'h70F0_F0F0_F0F0_F061, "R2 refused write absent");
      score();

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule